// File: doc/BRIEF.md
# Two-Port APB General-Purpose I/O Controller

This block is an APB slave that gives software control of sixteen general-purpose pins, arranged as two independent 8-bit ports named A and B. Each port has a data register and a direction register, and each pin has its own direction bit, so one port can mix inputs and outputs freely. On the pad side, every pin has three signals: an input level from the pad, an output level to the pad and an output enable.

The two direction registers use opposite senses. On port A, a direction bit of 1 turns the pin into an output. On port B, a direction bit of 0 turns the pin into an output. After reset all registers are zero. Port A therefore starts with every pin as an input, and port B starts with every pin driving 0.

Input levels pass through a two-stage synchronizer before software can read them. Reading a data register returns, bit by bit, the synchronized pad level for input pins and the stored output value for output pins. Every transfer completes without wait states. The base address is chosen by the system, and only the offsets inside the block are fixed.

Top module: `gpio2_ctrl`

## Requirements
- R1: After reset, all four registers read 0, `pa_oe` is 0x00, `pb_oe` is 0xFF and `pb_out` is 0x00.
- R2: A write to offset 0x00 sets `pa_out`, and a write to offset 0x08 sets `pb_out`. In both cases the new value takes bits [7:0] of `pwdata` and appears on the first clock edge of the access phase.
- R3: A write to offset 0x04 (the port A direction) sets `pa_oe` equal to the written bits [7:0], because a 1 makes a pin an output. The change appears in the same cycle as R2.
- R4: A write to offset 0x0C (the port B direction) sets `pb_oe` equal to the inverse of the written bits [7:0], because a 0 makes a pin an output.
- R5: For a pin configured as an input, a data-register read returns the pad level sampled two clock edges earlier, through a two-stage synchronizer.
- R6: For a pin configured as an output, a data-register read returns the last value written to that bit.
- R7: The direction registers read back the value stored in them, and bits [31:8] of `prdata` are always 0.
- R8: `pready` is always 1 and `pslverr` is always 0.
- R9: A write to any offset other than 0x00, 0x04, 0x08 or 0x0C changes no register and no pad output. A read from such an offset returns 0.
- R10: A write takes effect only when `psel`, `penable` and `pwrite` are all high. A setup phase without `penable` changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset inside the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while `psel` is high |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| pa_in | input | 8 | Port A pad input levels |
| pa_out | output | 8 | Port A pad output levels |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pad input levels |
| pb_out | output | 8 | Port B pad output levels |
| pb_oe | output | 8 | Port B pad output enables |

## Verification
Register writes become visible on the pad outputs and output enables right after the clock edge that ends the access phase. The bench's reference model updates on that same edge, and the bench compares the pads at every falling edge. A change on a pad input reaches read data after two rising edges, so the model keeps a two-deep history of the sampled inputs. The latency check samples `prdata` one and two falling edges after the input changes, and expects the old value first and then the new one. Read data is combinational from the registers, so the bench compares it in the same falling-edge window while `psel` is high.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;
  localparam int PORT_W  = 8;
  localparam int BUS_W   = 32;
  localparam int N_PORTS = 2;
  localparam int N_REGS  = 4;

  typedef enum logic [1:0] {
    REG_A_DATA = 2'd0,
    REG_A_DIR  = 2'd1,
    REG_B_DATA = 2'd2,
    REG_B_DIR  = 2'd3
  } gpio2_reg_e;

  // Per-bit merge: output pins return the stored value, input pins the pad.
  function automatic logic [PORT_W-1:0] merge_readback(
    input logic [PORT_W-1:0] stored,
    input logic [PORT_W-1:0] pad_sync,
    input logic [PORT_W-1:0] oe
  );
    return (stored & oe) | (pad_sync & ~oe);
  endfunction

  // Turns a direction register into output enables for the given polarity.
  function automatic logic [PORT_W-1:0] dir_to_oe(
    input logic [PORT_W-1:0] dir,
    input logic              one_is_output
  );
    return one_is_output ? dir : ~dir;
  endfunction
endpackage

// File: rtl/gpio2_sync.sv
module gpio2_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio2_apb_dec.sv
module gpio2_apb_dec
  import gpio2_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [N_REGS-1:0] wr_strobe,
  output logic [N_REGS-1:0] rd_sel
);
  localparam int IDX_W = $clog2(N_REGS);

  logic             mapped;
  logic [IDX_W-1:0] idx;

  assign mapped = (paddr[ADDR_W-1:IDX_W+2] == '0) && (paddr[1:0] == 2'b00);
  assign idx    = paddr[IDX_W+1:2];

  always_comb begin
    wr_strobe = '0;
    rd_sel    = '0;
    if (mapped && psel) begin
      if (pwrite && penable) wr_strobe[idx] = 1'b1;
      if (!pwrite)           rd_sel[idx]    = 1'b1;
    end
  end
endmodule

// File: rtl/gpio2_port.sv
module gpio2_port
  import gpio2_pkg::*;
#(
  parameter int W             = 8,
  parameter bit ONE_IS_OUTPUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic         wr_dir,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] data_rd,
  output logic [W-1:0] dir_rd
);
  logic [W-1:0] data_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] pad_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_data) data_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
    end
  end

  gpio2_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (pad_sync)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_to_oe(dir_q, ONE_IS_OUTPUT);
  assign data_rd = merge_readback(data_q, pad_sync, pad_oe);
  assign dir_rd  = dir_q;
endmodule

// File: rtl/gpio2_ctrl.sv
module gpio2_ctrl
  import gpio2_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe
);
  logic [N_REGS-1:0] wr_strobe;
  logic [N_REGS-1:0] rd_sel;

  logic [N_PORTS-1:0][PORT_W-1:0] pin_in;
  logic [N_PORTS-1:0][PORT_W-1:0] pin_out;
  logic [N_PORTS-1:0][PORT_W-1:0] pin_oe;
  logic [N_PORTS-1:0][PORT_W-1:0] data_rd;
  logic [N_PORTS-1:0][PORT_W-1:0] dir_rd;

  gpio2_apb_dec #(.ADDR_W(ADDR_W)) u_dec (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .wr_strobe(wr_strobe),
    .rd_sel   (rd_sel)
  );

  assign pin_in[0] = pa_in;
  assign pin_in[1] = pb_in;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    gpio2_port #(
      .W            (PORT_W),
      .ONE_IS_OUTPUT(p == 0)
    ) u_port (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_data(wr_strobe[2*p]),
      .wr_dir (wr_strobe[2*p+1]),
      .wdata  (pwdata[PORT_W-1:0]),
      .pad_in (pin_in[p]),
      .pad_out(pin_out[p]),
      .pad_oe (pin_oe[p]),
      .data_rd(data_rd[p]),
      .dir_rd (dir_rd[p])
    );
  end

  always_comb begin
    prdata = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (rd_sel[2*p])   prdata[PORT_W-1:0] = data_rd[p];
      if (rd_sel[2*p+1]) prdata[PORT_W-1:0] = dir_rd[p];
    end
  end

  assign pa_out  = pin_out[0];
  assign pa_oe   = pin_oe[0];
  assign pb_out  = pin_out[1];
  assign pb_oe   = pin_oe[1];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/gpio2_ctrl_chk.sv
module gpio2_ctrl_chk
  import gpio2_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [BUS_W-1:0]  pwdata,
  input logic [BUS_W-1:0]  prdata,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe,
  input logic [N_REGS-1:0] wr_strobe
);
  logic acc_wr;
  assign acc_wr = psel && penable && pwrite;

  // R2
  a_data_write_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && paddr == 'h0) |=> (pa_out == $past(pwdata[PORT_W-1:0])));

  // R3
  a_dir_polarity_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && paddr == 'h4) |=> (pa_oe == $past(pwdata[PORT_W-1:0])));

  // R4
  b_dir_polarity_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc_wr && paddr == 'hC) |=> (pb_oe == ~$past(pwdata[PORT_W-1:0])));

  // R10
  a_out_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(acc_wr && paddr == 'h0) |=> $stable(pa_out));

  // R9
  b_out_hold_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !(acc_wr && paddr == 'h8) |=> $stable(pb_out));

  // R7
  upper_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> (prdata[BUS_W-1:PORT_W] == '0));

  // R9
  one_strobe_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(wr_strobe));
endmodule

bind gpio2_ctrl gpio2_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .pclk     (pclk),
  .presetn  (presetn),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pwdata   (pwdata),
  .prdata   (prdata),
  .pa_out   (pa_out),
  .pa_oe    (pa_oe),
  .pb_out   (pb_out),
  .pb_oe    (pb_oe),
  .wr_strobe(wr_strobe)
);

// File: tb/gpio2_ctrl_bench.sv
module gpio2_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          pclk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [7:0]    pa_in = '0, pb_in = '0;
  logic [7:0]    pa_out, pa_oe, pb_out, pb_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  gpio2_ctrl #(.ADDR_W(AW)) u_gpio2_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
  );

  // Behavioural reference model
  logic [7:0] m_reg [4];
  logic [7:0] a_hist [$];
  logic [7:0] b_hist [$];

  always @(posedge pclk) begin
    if (!presetn) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
      a_hist = '{8'h00, 8'h00};
      b_hist = '{8'h00, 8'h00};
    end else begin
      if (psel && penable && pwrite) begin
        case (paddr)
          12'h000: m_reg[0] = pwdata[7:0];
          12'h004: m_reg[1] = pwdata[7:0];
          12'h008: m_reg[2] = pwdata[7:0];
          12'h00C: m_reg[3] = pwdata[7:0];
          default: ;
        endcase
      end
      a_hist.push_front(pa_in);
      b_hist.push_front(pb_in);
      while (a_hist.size() > 2) void'(a_hist.pop_back());
      while (b_hist.size() > 2) void'(b_hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_a_oe();
    return m_reg[1];
  endfunction
  function automatic logic [7:0] exp_b_oe();
    return ~m_reg[3];
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [7:0] v;
    logic [7:0] oe;
    v = 8'h00;
    case (a)
      12'h000: begin
        oe = exp_a_oe();
        for (int b = 0; b < 8; b++) v[b] = oe[b] ? m_reg[0][b] : a_hist[1][b];
      end
      12'h004: v = m_reg[1];
      12'h008: begin
        oe = exp_b_oe();
        for (int b = 0; b < 8; b++) v[b] = oe[b] ? m_reg[2][b] : b_hist[1][b];
      end
      12'h00C: v = m_reg[3];
      default: v = 8'h00;
    endcase
    return {24'h0, v};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the rising edge
  always @(negedge pclk) begin
    if (presetn && !done) begin
      check("R2 pa_out", {24'h0, pa_out}, {24'h0, m_reg[0]});
      check("R2 pb_out", {24'h0, pb_out}, {24'h0, m_reg[2]});
      check("R3 pa_oe", {24'h0, pa_oe}, {24'h0, exp_a_oe()});
      check("R4 pb_oe", {24'h0, pb_oe}, {24'h0, exp_b_oe()});
      check("R8 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
      if (psel && !pwrite) check("R5 R6 R7 R9 prdata", prdata, exp_read(paddr));
    end
  end

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge pclk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    check("R1 pa_oe", {24'h0, pa_oe}, 32'h00);
    check("R1 pb_oe", {24'h0, pb_oe}, 32'hFF);
    check("R1 pb_out", {24'h0, pb_out}, 32'h00);
    for (int i = 0; i < 4; i++) begin
      apb_read(AW'(i * 4), rd);
      check("R1 reg reads zero", rd, 32'h0);
    end
    check("R8 pready", {31'h0, pready}, 32'h1);
    check("R8 pslverr", {31'h0, pslverr}, 32'h0);

    // R3 / R2 / R5 / R6 on port A
    apb_write(12'h004, 32'h0000_00F0);
    check("R3 pa_oe after dir write", {24'h0, pa_oe}, 32'hF0);
    apb_write(12'h000, 32'h0000_00A5);
    check("R2 pa_out after data write", {24'h0, pa_out}, 32'hA5);
    pa_in = 8'h3C;
    repeat (3) @(negedge pclk);
    apb_read(12'h000, rd);
    check("R5 R6 port A mixed read", rd, 32'hAC);

    // R4 / R2 / R5 / R6 on port B
    apb_write(12'h00C, 32'h0000_000F);
    check("R4 pb_oe inverted", {24'h0, pb_oe}, 32'hF0);
    apb_write(12'h008, 32'h0000_005A);
    check("R2 pb_out after data write", {24'h0, pb_out}, 32'h5A);
    pb_in = 8'hFF;
    repeat (3) @(negedge pclk);
    apb_read(12'h008, rd);
    check("R5 R6 port B mixed read", rd, 32'h5F);

    // R7 direction readback, upper bits zero
    apb_read(12'h00C, rd);
    check("R7 B dir readback", rd, 32'h0F);
    apb_write(12'h004, 32'hFFFF_FF33);
    apb_read(12'h004, rd);
    check("R7 A dir upper zero", rd, 32'h33);

    // R9 unmapped offsets
    apb_write(12'h010, 32'h0000_00FF);
    apb_write(12'h402, 32'h0000_0000);
    apb_write(12'h001, 32'h0000_0000);
    check("R9 pa_out unchanged", {24'h0, pa_out}, 32'hA5);
    check("R9 pb_oe unchanged", {24'h0, pb_oe}, 32'hF0);
    apb_read(12'h010, rd);
    check("R9 unmapped read", rd, 32'h0);
    apb_read(12'h801, rd);
    check("R9 unmapped read hi", rd, 32'h0);

    // R10 setup phase alone does not write
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'h11;
    repeat (3) @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    check("R10 pa_out unchanged", {24'h0, pa_out}, 32'hA5);

    // R5 two-edge latency with port A all inputs
    apb_write(12'h004, 32'h0000_0000);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h000;
    @(negedge pclk);
    check("R5 before change", prdata, 32'h3C);
    pa_in = 8'h81;
    @(negedge pclk);
    check("R5 one edge later still old", prdata, 32'h3C);
    @(negedge pclk);
    check("R5 two edges later new", prdata, 32'h81);
    psel = 1'b0;
    repeat (2) @(negedge pclk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule